// File: doc/BRIEF.md
# State-Sequence Repetition Recognizer

This block watches a stream of per-cycle protocol state codes and raises a flag when one configured pattern has been seen. The pattern opens with a start state. It continues with a target state counted under one of three repetition rules. An optional forbidden state must not appear anywhere inside the span. A qualifier bit can gate the start state, so that leaving it counts only while an extra condition holds. Typical use is as a coverage or monitor tap beside a bus-protocol tracker whose state register drives `state_in`.

Only one attempt is tracked at a time. Every qualified start restarts it with a zero count. The outcome for the cycle in which a code is presented appears on the registered outputs right after the next rising clock edge. The configuration pins are captured while reset is asserted and are ignored afterwards.

Top module: `seqrep_recognizer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `clr` is sampled high, both outputs are 0. `clr` also drops the active attempt, so later non-start codes flag nothing.
- R2: When `cfg_qual_en` is 1, the start code opens an attempt only if `qual_in` is 1 in that cycle. Otherwise the code is treated like any other code.
- R3: Mode 0 (`cfg_mode`=2'd0, back-to-back). After the start, the target must appear on consecutive cycles. On the first following cycle that is neither target nor forbidden, a match is flagged (level and pulse together, one cycle) if the run length lies in `cfg_lo`..`cfg_hi`. The attempt then ends.
- R4: In mode 0, a run that grows past `cfg_hi` aborts the attempt at once with no match. When `cfg_hi_inf` is 1 there is no upper limit.
- R5: In mode 0, `cfg_lo`=0 lets a start followed directly by a non-target code match.
- R6: Mode 1 (`cfg_mode`=2'd1, scattered). Target occurrences after the start need not be adjacent. The level rises on the Nth occurrence (N=`cfg_lo`, 0 read as 1) together with a one-cycle pulse. The level stays high on every later cycle and falls on the (N+1)th occurrence, which ends the attempt.
- R7: Mode 2 or 3 (`cfg_mode`[1]=1, landing). Occurrences may be scattered. The level and pulse are high only in the cycle of the Nth occurrence, after which the attempt ends.
- R8: When `cfg_excl_en` is 1, the code `cfg_excl` seen during an attempt aborts it, clears any held level in that cycle, and prevents any match for that span.
- R9: The repetition count saturates at 255. An unbounded back-to-back run longer than 255 cycles still satisfies a lower limit of up to 255.
- R10: Configuration changes made after reset is released have no effect until the next reset.
- R11: A qualified start during an attempt restarts the count from zero. The old attempt's outcome for that same cycle is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; configuration is captured while low |
| clr | input | 1 | Synchronous clear of attempt and outputs |
| state_in | input | STATE_W | State code observed this cycle |
| qual_in | input | 1 | Qualifier for the start state |
| cfg_mode | input | 2 | Repetition rule: 0 back-to-back, 1 scattered, 2/3 landing |
| cfg_start | input | STATE_W | Start state code |
| cfg_target | input | STATE_W | Repeated state code |
| cfg_excl | input | STATE_W | Forbidden state code |
| cfg_excl_en | input | 1 | Enable the forbidden state |
| cfg_qual_en | input | 1 | Gate the start state with `qual_in` |
| cfg_lo | input | CNT_W | Lower bound / required count N |
| cfg_hi | input | CNT_W | Upper bound for mode 0 |
| cfg_hi_inf | input | 1 | No upper bound for mode 0 |
| match_hold | output | 1 | Match level |
| match_end | output | 1 | One-cycle pulse when a match completes |

## Verification
A wrong occurrence count shifts the edge of `match_hold` by one or more codes. That shift shows on the outputs in the very cycle after the Nth or (N+1)th target, so each pattern's expected cycle is checked exactly. A stale active flag after an abort, clear or restart produces a spurious or early flag on the next target codes, typically within two to four cycles. A wrapped counter in a long unbounded run shows as a missing match on the cycle that breaks the run.

// File: rtl/seqrep_pkg.sv
package seqrep_pkg;

    typedef enum logic [1:0] {
        MODE_CONSEC  = 2'd0,
        MODE_SCATTER = 2'd1,
        MODE_LAND    = 2'd2,
        MODE_LAND_B  = 2'd3
    } rep_mode_e;

    typedef struct packed {
        logic start;
        logic tgt;
        logic excl;
    } evt_t;

endpackage

// File: rtl/seqrep_cfg_capture.sv
module seqrep_cfg_capture
    import seqrep_pkg::*;
#(
    parameter int STATE_W = 3,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic [STATE_W-1:0] start_i,
    input  logic [STATE_W-1:0] tgt_i,
    input  logic [STATE_W-1:0] excl_i,
    input  logic               excl_en_i,
    input  logic               qual_en_i,
    input  logic [CNT_W-1:0]   lo_i,
    input  logic [CNT_W-1:0]   hi_i,
    input  logic               hi_inf_i,
    output rep_mode_e          mode_o,
    output logic [STATE_W-1:0] start_o,
    output logic [STATE_W-1:0] tgt_o,
    output logic [STATE_W-1:0] excl_o,
    output logic               excl_en_o,
    output logic               qual_en_o,
    output logic [CNT_W-1:0]   lo_o,
    output logic [CNT_W-1:0]   hi_o,
    output logic               hi_inf_o
);

    typedef struct packed {
        rep_mode_e          mode;
        logic [STATE_W-1:0] start;
        logic [STATE_W-1:0] tgt;
        logic [STATE_W-1:0] excl;
        logic               excl_en;
        logic               qual_en;
        logic [CNT_W-1:0]   lo;
        logic [CNT_W-1:0]   hi;
        logic               hi_inf;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Load only while reset is held; frozen afterwards.
    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.mode    = rep_mode_e'(mode_i);
            cfg_d.start   = start_i;
            cfg_d.tgt     = tgt_i;
            cfg_d.excl    = excl_i;
            cfg_d.excl_en = excl_en_i;
            cfg_d.qual_en = qual_en_i;
            cfg_d.lo      = lo_i;
            cfg_d.hi      = hi_i;
            cfg_d.hi_inf  = hi_inf_i;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign mode_o    = cfg_q.mode;
    assign start_o   = cfg_q.start;
    assign tgt_o     = cfg_q.tgt;
    assign excl_o    = cfg_q.excl;
    assign excl_en_o = cfg_q.excl_en;
    assign qual_en_o = cfg_q.qual_en;
    assign lo_o      = cfg_q.lo;
    assign hi_o      = cfg_q.hi;
    assign hi_inf_o  = cfg_q.hi_inf;

endmodule

// File: rtl/seqrep_event_decode.sv
module seqrep_event_decode
    import seqrep_pkg::*;
#(
    parameter int STATE_W = 3
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic               qual_i,
    input  logic [STATE_W-1:0] start_i,
    input  logic [STATE_W-1:0] tgt_i,
    input  logic [STATE_W-1:0] excl_i,
    input  logic               excl_en_i,
    input  logic               qual_en_i,
    output evt_t               evt_o
);

    always_comb begin
        evt_o.start = (state_i == start_i) && (!qual_en_i || qual_i);
        evt_o.tgt   = (state_i == tgt_i);
        evt_o.excl  = excl_en_i && (state_i == excl_i);
    end

endmodule

// File: rtl/seqrep_engine.sv
module seqrep_engine
    import seqrep_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  evt_t             evt,
    input  rep_mode_e        mode,
    input  logic [CNT_W-1:0] lo,
    input  logic [CNT_W-1:0] hi,
    input  logic             hi_inf,
    output logic             hold_o,
    output logic             pulse_o
);

    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             hold;
        logic             pulse;
    } eng_t;

    eng_t             st_d, st_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        need    = (mode != MODE_CONSEC && lo == '0) ? CNT_ONE : lo;
        cnt_inc = (st_q.cnt == CNT_SAT) ? st_q.cnt : st_q.cnt + CNT_ONE;

        st_d       = st_q;
        st_d.hold  = 1'b0;
        st_d.pulse = 1'b0;

        if (st_q.active) begin
            if (evt.excl) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                case (mode)
                    MODE_CONSEC: begin
                        if (evt.tgt) begin
                            if (!hi_inf && cnt_inc > hi) begin
                                st_d.active = 1'b0;
                                st_d.cnt    = '0;
                            end else begin
                                st_d.cnt = cnt_inc;
                            end
                        end else begin
                            st_d.active = 1'b0;
                            st_d.cnt    = '0;
                            if (st_q.cnt >= lo) begin
                                st_d.hold  = 1'b1;
                                st_d.pulse = 1'b1;
                            end
                        end
                    end
                    MODE_SCATTER: begin
                        if (evt.tgt) begin
                            if (st_q.cnt == need) begin
                                st_d.active = 1'b0;
                                st_d.cnt    = '0;
                            end else begin
                                st_d.cnt = cnt_inc;
                                if (cnt_inc == need) begin
                                    st_d.hold  = 1'b1;
                                    st_d.pulse = 1'b1;
                                end
                            end
                        end else if (st_q.cnt == need) begin
                            st_d.hold = 1'b1;
                        end
                    end
                    default: begin
                        if (evt.tgt) begin
                            st_d.cnt = cnt_inc;
                            if (cnt_inc == need) begin
                                st_d.hold   = 1'b1;
                                st_d.pulse  = 1'b1;
                                st_d.active = 1'b0;
                                st_d.cnt    = '0;
                            end
                        end
                    end
                endcase
            end
        end

        if (evt.start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end

        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o  = st_q.hold;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/seqrep_recognizer.sv
module seqrep_recognizer
    import seqrep_pkg::*;
#(
    parameter int STATE_W = 3,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [STATE_W-1:0] state_in,
    input  logic               qual_in,
    input  logic [1:0]         cfg_mode,
    input  logic [STATE_W-1:0] cfg_start,
    input  logic [STATE_W-1:0] cfg_target,
    input  logic [STATE_W-1:0] cfg_excl,
    input  logic               cfg_excl_en,
    input  logic               cfg_qual_en,
    input  logic [CNT_W-1:0]   cfg_lo,
    input  logic [CNT_W-1:0]   cfg_hi,
    input  logic               cfg_hi_inf,
    output logic               match_hold,
    output logic               match_end
);

    rep_mode_e          mode_q;
    logic [STATE_W-1:0] start_q, tgt_q, excl_q;
    logic               excl_en_q, qual_en_q, hi_inf_q;
    logic [CNT_W-1:0]   lo_q, hi_q;
    evt_t               evt;

    seqrep_cfg_capture #(.STATE_W(STATE_W), .CNT_W(CNT_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (cfg_mode),
        .start_i   (cfg_start),
        .tgt_i     (cfg_target),
        .excl_i    (cfg_excl),
        .excl_en_i (cfg_excl_en),
        .qual_en_i (cfg_qual_en),
        .lo_i      (cfg_lo),
        .hi_i      (cfg_hi),
        .hi_inf_i  (cfg_hi_inf),
        .mode_o    (mode_q),
        .start_o   (start_q),
        .tgt_o     (tgt_q),
        .excl_o    (excl_q),
        .excl_en_o (excl_en_q),
        .qual_en_o (qual_en_q),
        .lo_o      (lo_q),
        .hi_o      (hi_q),
        .hi_inf_o  (hi_inf_q)
    );

    seqrep_event_decode #(.STATE_W(STATE_W)) i_dec (
        .state_i   (state_in),
        .qual_i    (qual_in),
        .start_i   (start_q),
        .tgt_i     (tgt_q),
        .excl_i    (excl_q),
        .excl_en_i (excl_en_q),
        .qual_en_i (qual_en_q),
        .evt_o     (evt)
    );

    seqrep_engine #(.CNT_W(CNT_W)) i_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .evt     (evt),
        .mode    (mode_q),
        .lo      (lo_q),
        .hi      (hi_q),
        .hi_inf  (hi_inf_q),
        .hold_o  (match_hold),
        .pulse_o (match_end)
    );

endmodule

// File: rtl/seqrep_checker.sv
module seqrep_checker #(
    parameter int STATE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr,
    input logic [STATE_W-1:0] state_in,
    input logic [1:0]         mode_q,
    input logic [STATE_W-1:0] tgt_q,
    input logic [STATE_W-1:0] excl_q,
    input logic               excl_en_q,
    input logic               match_hold,
    input logic               match_end
);

    // R1: clear empties both outputs on the next cycle
    a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!match_hold && !match_end));

    // R6: a completion pulse never appears without the level
    a_r6_pulse_with_level: assert property (@(posedge clk) disable iff (!rst_n)
        match_end |-> match_hold);

    // R3: back-to-back matches are single-cycle events
    a_r3_consec_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0 && match_hold) |-> match_end);

    // R6: an extra target while holding ends the level
    a_r6_scatter_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1 && match_hold && state_in == tgt_q) |=> !match_hold);

    // R7: landing matches last one cycle
    a_r7_land_once: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && match_hold) |=> !match_hold);

    // R8: the forbidden code never yields a match level
    a_r8_excl_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (excl_en_q && state_in == excl_q) |=> !match_hold);

endmodule

bind seqrep_recognizer seqrep_checker #(.STATE_W(STATE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .state_in   (state_in),
    .mode_q     (mode_q),
    .tgt_q      (tgt_q),
    .excl_q     (excl_q),
    .excl_en_q  (excl_en_q),
    .match_hold (match_hold),
    .match_end  (match_end)
);

// File: tb/test_seqrep_recognizer.sv
`timescale 1ns/1ps
module test_seqrep_recognizer;

    localparam int SW = 3;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [SW-1:0] state_in = '0;
    logic          qual_in = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [SW-1:0] cfg_start = 3'd1;
    logic [SW-1:0] cfg_target = 3'd2;
    logic [SW-1:0] cfg_excl = 3'd3;
    logic          cfg_excl_en = 1'b0;
    logic          cfg_qual_en = 1'b0;
    logic [CW-1:0] cfg_lo = '0;
    logic [CW-1:0] cfg_hi = '0;
    logic          cfg_hi_inf = 1'b0;
    logic          match_hold, match_end;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    seqrep_recognizer #(.STATE_W(SW), .CNT_W(CW)) i_seqrep_recognizer (
        .clk(clk), .rst_n(rst_n), .clr(clr), .state_in(state_in), .qual_in(qual_in),
        .cfg_mode(cfg_mode), .cfg_start(cfg_start), .cfg_target(cfg_target),
        .cfg_excl(cfg_excl), .cfg_excl_en(cfg_excl_en), .cfg_qual_en(cfg_qual_en),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_hi_inf(cfg_hi_inf),
        .match_hold(match_hold), .match_end(match_end)
    );

    // {state[2:0], qual, exp_hold, exp_end}; landing mode, N=3, code 3 forbidden
    localparam int NV = 21;
    localparam logic [5:0] VEC [NV] = '{
        6'b001_0_00, 6'b011_0_00, 6'b100_0_00, 6'b001_0_00,
        6'b010_0_00, 6'b010_0_00, 6'b010_0_11, 6'b010_0_00,
        6'b000_0_00, 6'b001_0_00, 6'b010_0_00, 6'b000_0_00,
        6'b010_0_00, 6'b011_0_00, 6'b010_0_00, 6'b001_0_00,
        6'b010_0_00, 6'b000_0_00, 6'b010_0_00, 6'b000_0_00,
        6'b010_0_11
    };

    task automatic check(input logic eh, input logic ep, input string tag);
        checks++;
        if (match_hold !== eh || match_end !== ep) begin
            errors++;
            $display("FAIL %s: hold,end actual %b%b expected %b%b",
                     tag, match_hold, match_end, eh, ep);
        end
    endtask

    task automatic step(input logic [SW-1:0] s, input logic q, input logic c,
                        input logic eh, input logic ep, input string tag);
        @(negedge clk);
        state_in = s;
        qual_in  = q;
        clr      = c;
        @(posedge clk);
        #1;
        check(eh, ep, tag);
    endtask

    task automatic configure(input logic [1:0] m, input logic [CW-1:0] lo,
                             input logic [CW-1:0] hi, input logic inf,
                             input logic xen, input logic qen);
        @(negedge clk);
        rst_n       = 1'b0;
        clr         = 1'b0;
        state_in    = '0;
        cfg_mode    = m;
        cfg_lo      = lo;
        cfg_hi      = hi;
        cfg_hi_inf  = inf;
        cfg_excl_en = xen;
        cfg_qual_en = qen;
        repeat (2) @(posedge clk);
        #1;
        check(1'b0, 1'b0, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R7 R8: table walk, landing mode with exclusion (stated example)
        configure(2'd2, 8'd3, 8'd0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < NV; i++)
            step(VEC[i][5:3], VEC[i][2], 1'b0, VEC[i][1], VEC[i][0], "R7 R8 table");

        // R11: restart mid-attempt resets the count
        configure(2'd2, 8'd3, 8'd0, 1'b0, 1'b0, 1'b0);
        step(3'd1, 0, 0, 0, 0, "R11");
        step(3'd2, 0, 0, 0, 0, "R11");
        step(3'd2, 0, 0, 0, 0, "R11");
        step(3'd1, 0, 0, 0, 0, "R11");
        step(3'd2, 0, 0, 0, 0, "R11 after restart");
        step(3'd2, 0, 0, 0, 0, "R11 after restart");
        step(3'd2, 0, 0, 1, 1, "R11 third after restart");

        // R6: scattered, N=2
        configure(2'd1, 8'd2, 8'd0, 1'b0, 1'b1, 1'b0);
        step(3'd1, 0, 0, 0, 0, "R6");
        step(3'd2, 0, 0, 0, 0, "R6");
        step(3'd0, 0, 0, 0, 0, "R6");
        step(3'd2, 0, 0, 1, 1, "R6 Nth");
        step(3'd0, 0, 0, 1, 0, "R6 hold");
        step(3'd4, 0, 0, 1, 0, "R6 hold");
        step(3'd2, 0, 0, 0, 0, "R6 N+1 drop");
        step(3'd0, 0, 0, 0, 0, "R6 ended");
        // R8: forbidden code clears a held level
        step(3'd1, 0, 0, 0, 0, "R8");
        step(3'd2, 0, 0, 0, 0, "R8");
        step(3'd2, 0, 0, 1, 1, "R8 Nth");
        step(3'd3, 0, 0, 0, 0, "R8 excl drops");
        step(3'd0, 0, 0, 0, 0, "R8 stays low");
        // R1: clear while holding
        step(3'd1, 0, 0, 0, 0, "R1");
        step(3'd2, 0, 0, 0, 0, "R1");
        step(3'd2, 0, 0, 1, 1, "R1");
        step(3'd0, 0, 1, 0, 0, "R1 clear");
        step(3'd0, 0, 0, 0, 0, "R1 attempt gone");
        step(3'd2, 0, 0, 0, 0, "R1 attempt gone");
        step(3'd2, 0, 0, 0, 0, "R1 attempt gone");

        // R3: back-to-back, 2..3
        configure(2'd0, 8'd2, 8'd3, 1'b0, 1'b0, 1'b0);
        step(3'd1, 0, 0, 0, 0, "R3");
        step(3'd2, 0, 0, 0, 0, "R3");
        step(3'd2, 0, 0, 0, 0, "R3");
        step(3'd4, 0, 0, 1, 1, "R3 run of 2");
        step(3'd1, 0, 0, 0, 0, "R3");
        step(3'd2, 0, 0, 0, 0, "R3");
        step(3'd4, 0, 0, 0, 0, "R3 run of 1 short");
        // R4: run of 4 exceeds limit
        step(3'd1, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 4; i++) step(3'd2, 0, 0, 0, 0, "R4 run");
        step(3'd4, 0, 0, 0, 0, "R4 aborted");

        // R4: unbounded
        configure(2'd0, 8'd2, 8'd3, 1'b1, 1'b0, 1'b0);
        step(3'd1, 0, 0, 0, 0, "R4 inf");
        for (int i = 0; i < 6; i++) step(3'd2, 0, 0, 0, 0, "R4 inf run");
        step(3'd4, 0, 0, 1, 1, "R4 inf match");

        // R5: zero lower bound
        configure(2'd0, 8'd0, 8'd3, 1'b0, 1'b0, 1'b0);
        step(3'd1, 0, 0, 0, 0, "R5");
        step(3'd4, 0, 0, 1, 1, "R5 empty run");

        // R9: saturation at 255
        configure(2'd0, 8'd200, 8'd0, 1'b1, 1'b0, 1'b0);
        step(3'd1, 0, 0, 0, 0, "R9");
        for (int i = 0; i < 300; i++) step(3'd2, 0, 0, 0, 0, "R9 run");
        step(3'd4, 0, 0, 1, 1, "R9 saturated match");

        // R2: qualifier on the start code
        configure(2'd2, 8'd1, 8'd0, 1'b0, 1'b0, 1'b1);
        step(3'd1, 0, 0, 0, 0, "R2");
        step(3'd2, 0, 0, 0, 0, "R2 unqualified start");
        step(3'd1, 1, 0, 0, 0, "R2");
        step(3'd2, 0, 0, 1, 1, "R2 qualified start");

        // R10: config changes after reset are ignored
        configure(2'd2, 8'd1, 8'd0, 1'b0, 1'b0, 1'b0);
        cfg_mode = 2'd0;
        cfg_lo   = 8'd5;
        step(3'd1, 0, 0, 0, 0, "R10");
        step(3'd2, 0, 0, 1, 1, "R10 old mode kept");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule